// File: doc/BRIEF.md
# Software-Refilled Address Translation Buffer

This block is a small, fully associative translation cache that sits between a load/store unit and memory. Each request carries a 32-bit virtual address, split into a 12-bit page offset in the low bits and a 20-bit page number above it. When a valid entry holds the requested page number, the block returns the physical address one cycle later. That address is the entry's frame number with the untouched offset appended. The block also marks the entry as used, and as modified when the access was a store.

The block never walks page tables itself. A lookup that finds no valid entry traps with a cause code. So does a store to a page whose entry does not allow writes. On either trap, the whole faulting virtual address is kept in a bad-address register. Software then decides what to load and where. It writes an entry into a slot it names explicitly, and it can read any slot back, including the use and modified bits. The trapped access is then retried and must hit. Choosing victims, swapping pages and replacement order are all left to software.

Top module: `tlb_xlate`

## Requirements
- R1: The page number is `req_vaddr[31:12]`. A request hits only when some entry has its valid bit set and a stored page number equal to the request's. An entry whose page number matches but whose valid bit is 0 is a miss.
- R2: A request accepted on a clock edge that hits, and is allowed, gives `xl_ok`=1 for exactly the following cycle. In that cycle `xl_paddr` = {entry frame number, `req_vaddr[11:0]`}. `xl_ok` is 0 in every cycle that does not follow such a request.
- R3: `fault_cause` is a one-cycle pulse in the cycle after the request and is 0 otherwise. Its encoding is 0 = none, 1 = load miss, 2 = store miss, 3 = store to a non-writable page.
- R4: A store that hits an entry whose writable bit is 0 gives cause 3 and `xl_ok`=0. It sets neither the use bit nor the modified bit.
- R5: On every fault, `bad_vaddr` takes the full 32-bit request address. It holds its value while no fault occurs.
- R6: A successful translation sets the entry's use bit. A successful store also sets its modified bit.
- R7: A software write (`sw_we`=1) to slot `sw_widx` loads the page number, frame number, valid bit and writable bit, and clears the slot's use and modified bits. A retry of the trapped access then hits.
- R8: When a software write and a successful lookup target the same slot in the same cycle, the written values win and that cycle's use/modified update is dropped. The lookup itself is answered from the contents held before the write.
- R9: Reset clears every valid, use and modified bit, the bad-address register, `xl_ok` and `fault_cause`.
- R10: When several valid entries match, the entry with the lowest slot index supplies the frame number and receives the use/modified update.
- R11: The read port returns, combinationally, the page number, frame number, valid, writable, use and modified bits of slot `sw_ridx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 32 | Virtual address of the request |
| xl_ok | output | 1 | Translation succeeded (cycle after request) |
| xl_paddr | output | 32 | Physical address, meaningful while `xl_ok` is 1 |
| fault_cause | output | 2 | Fault pulse: 0 none, 1 load miss, 2 store miss, 3 write-protect |
| bad_vaddr | output | 32 | Last faulting virtual address |
| sw_we | input | 1 | Software entry write strobe |
| sw_widx | input | 2 | Slot to write |
| sw_vpn | input | 20 | Page number to install |
| sw_pfn | input | 20 | Frame number to install |
| sw_valid | input | 1 | Valid bit to install |
| sw_dirty | input | 1 | Writable bit to install |
| sw_ridx | input | 2 | Slot to read back |
| rd_vpn | output | 20 | Page number of slot `sw_ridx` |
| rd_pfn | output | 20 | Frame number of slot `sw_ridx` |
| rd_valid | output | 1 | Valid bit of slot `sw_ridx` |
| rd_dirty | output | 1 | Writable bit of slot `sw_ridx` |
| rd_use | output | 1 | Use bit of slot `sw_ridx` |
| rd_mod | output | 1 | Modified bit of slot `sw_ridx` |

## Verification
The bench builds the block with its default parameters: four slots, 12 offset bits and 20-bit frame numbers, so physical addresses are 32 bits wide. Four slots against random page numbers drawn from only eight values make duplicate matches, stale invalid matches and write/lookup collisions on one slot frequent within a few hundred cycles. Directed steps replay a load miss with refill, a write-protect trap, and a store miss whose refill makes the retry modify the page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_RD_MISS = 2'd1,
    FLT_WR_MISS = 2'd2,
    FLT_WR_PROT = 2'd3
  } flt_cause_e;
endpackage

// File: rtl/tlb_match.sv
// Parallel tag compare with lowest-index priority select.
module tlb_match #(
  parameter int NUM_ENT = 4,
  parameter int VPN_W   = 20,
  parameter int IDX_W   = 2
) (
  input  logic [VPN_W-1:0]              key,
  input  logic [NUM_ENT-1:0][VPN_W-1:0] tags,
  input  logic [NUM_ENT-1:0]            vld,
  output logic                          hit,
  output logic [IDX_W-1:0]              idx
);
  logic [NUM_ENT-1:0] eq;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    assign eq[g] = vld[g] && (tags[g] == key);
  end

  assign hit = |eq;

  always_comb begin
    idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_store.sv
// Entry storage: software writes by index, hardware sets use/modified.
module tlb_store #(
  parameter int NUM_ENT = 4,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int IDX_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [VPN_W-1:0]              wr_vpn,
  input  logic [PFN_W-1:0]              wr_pfn,
  input  logic                          wr_v,
  input  logic                          wr_d,
  input  logic                          tch_en,
  input  logic [IDX_W-1:0]              tch_idx,
  input  logic                          tch_mod,
  output logic [NUM_ENT-1:0][VPN_W-1:0] tags,
  output logic [NUM_ENT-1:0][PFN_W-1:0] pfns,
  output logic [NUM_ENT-1:0]            vld,
  output logic [NUM_ENT-1:0]            drt,
  output logic [NUM_ENT-1:0]            used,
  output logic [NUM_ENT-1:0]            modf
);
  logic [NUM_ENT-1:0][VPN_W-1:0] tags_d;
  logic [NUM_ENT-1:0][PFN_W-1:0] pfns_d;
  logic [NUM_ENT-1:0]            vld_d, drt_d, used_d, modf_d;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic sel_wr, sel_tch;
    assign sel_wr  = wr_en && (wr_idx == IDX_W'(g));
    assign sel_tch = tch_en && (tch_idx == IDX_W'(g));

    always_comb begin
      tags_d[g] = tags[g];
      pfns_d[g] = pfns[g];
      vld_d[g]  = vld[g];
      drt_d[g]  = drt[g];
      used_d[g] = used[g];
      modf_d[g] = modf[g];
      if (sel_wr) begin
        tags_d[g] = wr_vpn;
        pfns_d[g] = wr_pfn;
        vld_d[g]  = wr_v;
        drt_d[g]  = wr_d;
        used_d[g] = 1'b0;
        modf_d[g] = 1'b0;
      end else if (sel_tch) begin
        used_d[g] = 1'b1;
        if (tch_mod) modf_d[g] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tags[g] <= '0;
        pfns[g] <= '0;
        vld[g]  <= 1'b0;
        drt[g]  <= 1'b0;
        used[g] <= 1'b0;
        modf[g] <= 1'b0;
      end else if (sel_wr || sel_tch) begin
        tags[g] <= tags_d[g];
        pfns[g] <= pfns_d[g];
        vld[g]  <= vld_d[g];
        drt[g]  <= drt_d[g];
        used[g] <= used_d[g];
        modf[g] <= modf_d[g];
      end
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
// Fully associative translation buffer with software refill.
module tlb_xlate #(
  parameter int NUM_ENT = 4,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 20,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int IDX_W  = $clog2(NUM_ENT),
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             xl_ok,
  output logic [PA_W-1:0]  xl_paddr,
  output logic [1:0]       fault_cause,
  output logic [VA_W-1:0]  bad_vaddr,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_widx,
  input  logic [VPN_W-1:0] sw_vpn,
  input  logic [PFN_W-1:0] sw_pfn,
  input  logic             sw_valid,
  input  logic             sw_dirty,
  input  logic [IDX_W-1:0] sw_ridx,
  output logic [VPN_W-1:0] rd_vpn,
  output logic [PFN_W-1:0] rd_pfn,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic             rd_use,
  output logic             rd_mod
);
  import tlb_pkg::*;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Entry storage and matching
  logic [NUM_ENT-1:0][VPN_W-1:0] tags;
  logic [NUM_ENT-1:0][PFN_W-1:0] pfns;
  logic [NUM_ENT-1:0]            vld, drt, used, modf;
  logic                          hit;
  logic [IDX_W-1:0]              hit_idx;
  logic                          tch_en, allow;

  tlb_match #(.NUM_ENT(NUM_ENT), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_match (
    .key  (req_vaddr[VA_W-1:OFF_W]),
    .tags (tags),
    .vld  (vld),
    .hit  (hit),
    .idx  (hit_idx)
  );

  tlb_store #(.NUM_ENT(NUM_ENT), .VPN_W(VPN_W), .PFN_W(PFN_W), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (sw_we),
    .wr_idx  (sw_widx),
    .wr_vpn  (sw_vpn),
    .wr_pfn  (sw_pfn),
    .wr_v    (sw_valid),
    .wr_d    (sw_dirty),
    .tch_en  (tch_en),
    .tch_idx (hit_idx),
    .tch_mod (req_store),
    .tags    (tags),
    .pfns    (pfns),
    .vld     (vld),
    .drt     (drt),
    .used    (used),
    .modf    (modf)
  );

  // Lookup decision
  flt_cause_e      cause_d;
  logic            ok_d, flt_en;
  logic [PA_W-1:0] paddr_d;

  always_comb begin
    cause_d = FLT_NONE;
    allow   = 1'b0;
    if (req_valid) begin
      if (!hit)                          cause_d = req_store ? FLT_WR_MISS : FLT_RD_MISS;
      else if (req_store && !drt[hit_idx]) cause_d = FLT_WR_PROT;
      else                               allow   = 1'b1;
    end
  end

  assign ok_d    = allow;
  assign flt_en  = (cause_d != FLT_NONE);
  assign paddr_d = {pfns[hit_idx], req_vaddr[OFF_W-1:0]};
  // A software write to the same slot overrides the hardware update
  assign tch_en  = allow && !(sw_we && (sw_widx == hit_idx));

  // Output registers
  logic             ok_q;
  flt_cause_e       cause_q;
  logic [PA_W-1:0]  paddr_q;
  logic [VA_W-1:0]  bad_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ok_q    <= 1'b0;
      cause_q <= FLT_NONE;
    end else begin
      ok_q    <= ok_d;
      cause_q <= cause_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  paddr_q <= '0;
    else if (ok_d)   paddr_q <= paddr_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  bad_q <= '0;
    else if (flt_en) bad_q <= req_vaddr;
  end

  assign xl_ok       = ok_q;
  assign xl_paddr    = paddr_q;
  assign fault_cause = cause_q;
  assign bad_vaddr   = bad_q;

  // Software read-back
  assign rd_vpn   = tags[sw_ridx];
  assign rd_pfn   = pfns[sw_ridx];
  assign rd_valid = vld[sw_ridx];
  assign rd_dirty = drt[sw_ridx];
  assign rd_use   = used[sw_ridx];
  assign rd_mod   = modf[sw_ridx];
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PA_W  = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_store,
  input logic [VA_W-1:0] req_vaddr,
  input logic            xl_ok,
  input logic [PA_W-1:0] xl_paddr,
  input logic [1:0]      fault_cause,
  input logic [VA_W-1:0] bad_vaddr
);
  a_r2_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> (!xl_ok && fault_cause == 2'd0));

  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    xl_ok |-> xl_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));

  a_r3_fault_excludes_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_cause != 2'd0) |-> !xl_ok);

  a_r3_load_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_cause == 2'd1) |-> !$past(req_store));

  a_r3_store_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_cause[1]) |-> $past(req_store));

  a_r5_bad_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_cause != 2'd0) |-> bad_vaddr == $past(req_vaddr));

  a_r5_bad_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_cause == 2'd0) |-> $stable(bad_vaddr));
endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_store   (req_store),
  .req_vaddr   (req_vaddr),
  .xl_ok       (xl_ok),
  .xl_paddr    (xl_paddr),
  .fault_cause (fault_cause),
  .bad_vaddr   (bad_vaddr)
);

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
  localparam int CLK_NS = 10;
  localparam int NE     = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        xl_ok;
  logic [31:0] xl_paddr;
  logic [1:0]  fault_cause;
  logic [31:0] bad_vaddr;
  logic        sw_we = 1'b0, sw_valid = 1'b0, sw_dirty = 1'b0;
  logic [1:0]  sw_widx = '0, sw_ridx = '0;
  logic [19:0] sw_vpn = '0, sw_pfn = '0;
  logic [19:0] rd_vpn, rd_pfn;
  logic        rd_valid, rd_dirty, rd_use, rd_mod;

  always #(CLK_NS / 2) clk = ~clk;

  tlb_xlate u_tlb_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_vaddr(req_vaddr), .xl_ok(xl_ok), .xl_paddr(xl_paddr),
    .fault_cause(fault_cause), .bad_vaddr(bad_vaddr), .sw_we(sw_we),
    .sw_widx(sw_widx), .sw_vpn(sw_vpn), .sw_pfn(sw_pfn), .sw_valid(sw_valid),
    .sw_dirty(sw_dirty), .sw_ridx(sw_ridx), .rd_vpn(rd_vpn), .rd_pfn(rd_pfn),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_use(rd_use), .rd_mod(rd_mod)
  );

  int n_run = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [19:0] m_vpn [NE];
  logic [19:0] m_pfn [NE];
  bit          m_v [NE], m_d [NE], m_u [NE], m_m [NE];
  bit          e_ok = 1'b0;
  logic [1:0]  e_cause = '0;
  logic [31:0] e_pa = '0, e_bad = '0;

  always @(posedge clk) begin : model
    int hi;
    hi = -1;
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) begin
        m_vpn[i] = '0; m_pfn[i] = '0;
        m_v[i] = 0; m_d[i] = 0; m_u[i] = 0; m_m[i] = 0;
      end
      e_ok = 0; e_cause = 0; e_bad = 0;
    end else begin
      e_ok = 0; e_cause = 0;
      if (req_valid) begin
        for (int i = NE - 1; i >= 0; i--)
          if (m_v[i] && m_vpn[i] == req_vaddr[31:12]) hi = i;
        if (hi < 0)                        e_cause = req_store ? 2'd2 : 2'd1;
        else if (req_store && !m_d[hi])    e_cause = 2'd3;
        else begin e_ok = 1; e_pa = {m_pfn[hi], req_vaddr[11:0]}; end
        if (e_cause != 0) e_bad = req_vaddr;
      end
      if (sw_we) begin
        m_vpn[sw_widx] = sw_vpn; m_pfn[sw_widx] = sw_pfn;
        m_v[sw_widx] = sw_valid; m_d[sw_widx] = sw_dirty;
        m_u[sw_widx] = 0; m_m[sw_widx] = 0;
      end
      if (e_ok && !(sw_we && int'(sw_widx) == hi)) begin
        m_u[hi] = 1;
        if (req_store) m_m[hi] = 1;
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    chk("R2 xl_ok", {31'b0, xl_ok}, {31'b0, e_ok});
    if (e_ok) chk("R2 xl_paddr", xl_paddr, e_pa);
    chk("R3 fault_cause", {30'b0, fault_cause}, {30'b0, e_cause});
    chk("R5 bad_vaddr", bad_vaddr, e_bad);
    chk("R11 rd_vpn", {12'b0, rd_vpn}, {12'b0, m_vpn[sw_ridx]});
    chk("R11 rd_pfn", {12'b0, rd_pfn}, {12'b0, m_pfn[sw_ridx]});
    chk("R11 rd_flags", {28'b0, rd_valid, rd_dirty, rd_use, rd_mod},
        {28'b0, m_v[sw_ridx], m_d[sw_ridx], m_u[sw_ridx], m_m[sw_ridx]});
  end

  task automatic do_req(input bit st, input logic [31:0] va);
    @(negedge clk); #1;
    req_valid = 1; req_store = st; req_vaddr = va;
    @(negedge clk); #1;
    req_valid = 0;
  endtask

  task automatic do_wr(input int idx, input logic [19:0] vpn, input logic [19:0] pfn,
                       input bit v, input bit d);
    @(negedge clk); #1;
    sw_we = 1; sw_widx = 2'(idx); sw_vpn = vpn; sw_pfn = pfn; sw_valid = v; sw_dirty = d;
    @(negedge clk); #1;
    sw_we = 0;
  endtask

  task automatic peek(input int idx);
    sw_ridx = 2'(idx);
    #1;
  endtask

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9 xl_ok", {31'b0, xl_ok}, 32'd0);
    chk("R9 fault_cause", {30'b0, fault_cause}, 32'd0);
    chk("R9 bad_vaddr", bad_vaddr, 32'd0);
    for (int i = 0; i < NE; i++) begin
      peek(i);
      chk("R9 v/u/m", {29'b0, rd_valid, rd_use, rd_mod}, 32'd0);
    end
    #1 rst_n = 1;
    repeat (4) @(negedge clk);

    // R1/R3: matching page number but invalid -> load miss
    do_wr(1, 20'd3, 20'd0, 0, 0);
    do_req(0, 32'h0000_3C9A);
    chk("R1 invalid match misses", {30'b0, fault_cause}, 32'd1);
    chk("R5 bad addr on load miss", bad_vaddr, 32'h0000_3C9A);

    // R7: refill then retry hits; R6 use bit set
    do_wr(1, 20'd3, 20'd0, 1, 0);
    do_req(0, 32'h0000_3C9A);
    chk("R7 retry hits", {31'b0, xl_ok}, 32'd1);
    chk("R2 paddr", xl_paddr, 32'h0000_0C9A);
    peek(1);
    chk("R6 use set, mod clear", {30'b0, rd_use, rd_mod}, 32'b10);

    // R4: store to non-writable page
    do_req(1, 32'h0000_3C9A);
    chk("R4 write protect", {30'b0, fault_cause}, 32'd3);
    chk("R4 no translate", {31'b0, xl_ok}, 32'd0);
    peek(1);
    chk("R4 mod untouched", {31'b0, rd_mod}, 32'd0);

    // R3: store miss, refill writable, retry sets modified
    do_req(1, 32'h0000_2F08);
    chk("R3 store miss", {30'b0, fault_cause}, 32'd2);
    chk("R5 bad addr on store miss", bad_vaddr, 32'h0000_2F08);
    do_wr(2, 20'd2, 20'd4, 1, 1);
    peek(2);
    chk("R7 write clears use/mod", {30'b0, rd_use, rd_mod}, 32'd0);
    do_req(1, 32'h0000_2F08);
    chk("R2 store paddr", xl_paddr, 32'h0000_4F08);
    peek(2);
    chk("R6 store sets use+mod", {30'b0, rd_use, rd_mod}, 32'b11);
    do_req(0, 32'h0000_3001);
    chk("R5 bad held on hit", bad_vaddr, 32'h0000_2F08);

    // R10: duplicate matches, lowest slot wins
    do_wr(3, 20'd7, 20'h33, 1, 1);
    do_wr(0, 20'd7, 20'h11, 1, 1);
    do_req(0, 32'h0000_7ABC);
    chk("R10 lowest slot", xl_paddr, 32'h0001_1ABC);
    peek(3);
    chk("R10 higher slot untouched", {31'b0, rd_use}, 32'd0);

    // R8: collision of software write and lookup on slot 0
    @(negedge clk); #1;
    req_valid = 1; req_store = 1; req_vaddr = 32'h0000_7123;
    sw_we = 1; sw_widx = 2'd0; sw_vpn = 20'd7; sw_pfn = 20'h22; sw_valid = 1; sw_dirty = 1;
    @(negedge clk); #1;
    req_valid = 0; sw_we = 0;
    chk("R8 lookup uses old entry", xl_paddr, 32'h0001_1123);
    peek(0);
    chk("R8 write wins", {12'b0, rd_pfn}, 32'h22);
    chk("R8 update dropped", {30'b0, rd_use, rd_mod}, 32'd0);

    // Random traffic compared every cycle against the model
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      @(negedge clk); #1;
      r = $urandom;
      req_valid = r[0]; req_store = r[1];
      req_vaddr = {17'b0, r[4:2], r[16:5]};
      sw_we = (r[7:5] == 3'd0); sw_widx = r[9:8];
      sw_vpn = {17'b0, r[12:10]}; sw_pfn = {12'b0, r[20:13]};
      sw_valid = r[21] | r[22]; sw_dirty = r[23]; sw_ridx = r[25:24];
    end
    @(negedge clk); #1;
    req_valid = 0; sw_we = 0;
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule